// File: doc/BRIEF.md
# Prioritised Interrupt Aggregator

This block collects up to 31 edge-signalled interrupt sources and drives one interrupt request line into a single processor core. Sources carry ids 1 to 31; id 0 is reserved. Every source has a 3-bit priority. A 3-bit threshold masks sources whose priority is not strictly above it. A rising edge on an enabled source latches a pending bit. The block then works out the most urgent pending source, publishes its id in a claim register and raises the core line.

Software reaches the block through a plain 32-bit register port. A write happens on any clock where the write strobe is high. A read returns the addressed register combinationally. An interrupt handler reads the claim register to learn which source to serve. When it is done, it writes that id back to the same address. That write clears the source's pending bit, pulls the core line low for one cycle and starts a fresh arbitration over the remaining requests.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, the enable word, the pending word, the threshold and the claim register read 0, and `irq_o` is low.
- R2: A source's pending bit is set at a clock edge only if its input was low at the previous edge, is high at this edge, and its enable bit is set at this edge. An input that stays high never sets the bit a second time.
- R3: Id 0 is inert. Bit 0 of the enable word (0x2000) and of the pending word (0x1000) always reads 0. The word at offset 0 reads 0 and ignores writes.
- R4: A pending source takes part in arbitration only if its priority is strictly greater than the threshold. A priority equal to the threshold is masked.
- R5: Among the eligible sources, the highest priority wins. When priorities are equal, the lowest id wins.
- R6: One clock edge after any change to pending, enable, priority or threshold, the claim register (0x200004) holds the winning id and `irq_o` is high. When no source is eligible, the claim register reads 0 and `irq_o` is low.
- R7: A write of an id in 1..31 to 0x200004 clears that id's pending bit at the same edge. It forces the claim register to 0 and `irq_o` low for the following cycle. At the edge after that, the next winner is presented.
- R8: A write to 0x200004 of 0, of a value above 31, or of an id that is not pending leaves all pending bits unchanged. It still drops `irq_o` for one cycle.
- R9: The priority words and the threshold word (0x200000) keep only bits [2:0] of the written data. They read back as values 0 to 7.
- R10: Register map: the priority of source n is at 4·n, pending is at 0x1000 and is read-only, enable is at 0x2000, the threshold is at 0x200000 and claim/complete is at 0x200004. Any other address reads 0.
- R11: If a source's rising edge and a completion write for the same id fall on the same edge, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| src_i | input | 32 | Source inputs, bit n for id n; bit 0 is ignored |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 22 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench goes after tie-breaks between equal priorities and after a priority that exactly equals the threshold. A design that got the tie-break wrong would report the higher id. A design that compared with >= would raise the line for a masked source. It also drives edges on disabled sources and holds a level high across a completion. A design that sampled levels or latched regardless of enable would show phantom pending bits. Completion writes with id 0, with an out-of-range value whose low bits alias a pending id, and on the same edge as a new edge of that id catch decoders that truncate the id or let the clear win over the set.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int ADDR_W = 22;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 22'h001000;
  localparam logic [ADDR_W-1:0] OFS_EN    = 22'h002000;
  localparam logic [ADDR_W-1:0] OFS_THR   = 22'h200000;
  localparam logic [ADDR_W-1:0] OFS_CLAIM = 22'h200004;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [ID_W-1:0]   idx
);

  localparam int PRIO_TOP = ID_W + 2;

  always_comb begin
    sel = SEL_NONE;
    idx = addr[PRIO_TOP-1:2];
    if (addr[ADDR_W-1:PRIO_TOP] == '0 && addr[1:0] == 2'b00) begin
      sel = SEL_PRIO;
    end else if (addr == OFS_PEND) begin
      sel = SEL_PEND;
    end else if (addr == OFS_EN) begin
      sel = SEL_EN;
    end else if (addr == OFS_THR) begin
      sel = SEL_THR;
    end else if (addr == OFS_CLAIM) begin
      sel = SEL_CLAIM;
    end
  end

endmodule

// File: rtl/irq_hub_edge.sv
module irq_hub_edge #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] enable,
  output logic [NSRC-1:0] rise
);

  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= src;
    end
  end

  assign rise = src & ~prev_q & enable;

endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic [NSRC-1:0]             pending,
  input  logic [PRIO_W-1:0]           thr,
  output logic [ID_W-1:0]             win_id,
  output logic                        win_valid
);

  logic [NSRC-1:0] elig;

  // per-source qualification: pending and strictly above threshold
  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    if (i == 0) begin : g_rsv
      assign elig[i] = 1'b0;
    end else begin : g_src
      assign elig[i] = pending[i] && (prio[i] > thr);
    end
  end

  // ascending scan; strict compare keeps the lowest id on ties
  logic [PRIO_W-1:0] best_prio;
  always_comb begin
    win_id    = '0;
    win_valid = 1'b0;
    best_prio = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i] && (!win_valid || prio[i] > best_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        best_prio = prio[i];
      end
    end
  end

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  reg_sel_e                    sel,
  input  logic [ID_W-1:0]             idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NSRC-1:0]             rise,
  input  logic                        clr_ok,
  input  logic [ID_W-1:0]             clr_id,
  input  logic [ID_W-1:0]             claim,
  output logic [NSRC-1:0][PRIO_W-1:0] prio_q,
  output logic [NSRC-1:0]             enable_q,
  output logic [NSRC-1:0]             pending_q,
  output logic [PRIO_W-1:0]           thr_q,
  output logic [DATA_W-1:0]           rdata
);

  // ---------------- priority words, one per source ----------------
  assign prio_q[0] = '0;
  for (genvar i = 1; i < NSRC; i++) begin : g_prio
    logic prio_ld;
    assign prio_ld = we && (sel == SEL_PRIO) && (idx == ID_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
      end else if (prio_ld) begin
        prio_q[i] <= wdata[PRIO_W-1:0];
      end
    end
  end

  // ---------------- enable and threshold ----------------
  logic en_ld, thr_ld;
  logic [NSRC-1:0] enable_d;

  assign en_ld    = we && (sel == SEL_EN);
  assign thr_ld   = we && (sel == SEL_THR);
  assign enable_d = wdata[NSRC-1:0] & ~NSRC'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (en_ld) begin
      enable_q <= enable_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_ld) begin
      thr_q <= wdata[PRIO_W-1:0];
    end
  end

  // ---------------- pending ----------------
  logic [NSRC-1:0] clr_mask, pending_d;

  always_comb begin
    clr_mask = '0;
    if (clr_ok) begin
      clr_mask[clr_id] = 1'b1;
    end
    // a new edge outranks a completion of the same id
    pending_d    = (pending_q & ~clr_mask) | rise;
    pending_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else begin
      pending_q <= pending_d;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    unique case (sel)
      SEL_PRIO:  rdata = DATA_W'(prio_q[idx]);
      SEL_PEND:  rdata = DATA_W'(pending_q);
      SEL_EN:    rdata = DATA_W'(enable_q);
      SEL_THR:   rdata = DATA_W'(thr_q);
      SEL_CLAIM: rdata = DATA_W'(claim);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam int ID_W = $clog2(NSRC);

  reg_sel_e                    sel;
  logic [ID_W-1:0]             idx;
  logic [NSRC-1:0]             rise;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]             enable_q, pending_q;
  logic [PRIO_W-1:0]           thr_q;
  logic [ID_W-1:0]             win_id;
  logic                        win_valid;
  logic [ID_W-1:0]             claim_q, claim_d;
  logic                        irq_q, irq_d;
  logic                        cmpl_wr, clr_ok;

  irq_hub_decode #(.NSRC(NSRC)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (idx)
  );

  irq_hub_edge #(.NSRC(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src_i),
    .enable (enable_q),
    .rise   (rise)
  );

  assign cmpl_wr = bus_we && (sel == SEL_CLAIM);
  assign clr_ok  = cmpl_wr && (bus_wdata[DATA_W-1:ID_W] == '0) &&
                   (bus_wdata[ID_W-1:0] != '0);

  irq_hub_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .sel       (sel),
    .idx       (idx),
    .wdata     (bus_wdata),
    .rise      (rise),
    .clr_ok    (clr_ok),
    .clr_id    (bus_wdata[ID_W-1:0]),
    .claim     (claim_q),
    .prio_q    (prio_q),
    .enable_q  (enable_q),
    .pending_q (pending_q),
    .thr_q     (thr_q),
    .rdata     (bus_rdata)
  );

  irq_hub_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .prio      (prio_q),
    .pending   (pending_q),
    .thr       (thr_q),
    .win_id    (win_id),
    .win_valid (win_valid)
  );

  // claim/line next state: a completion write blanks the line for a cycle
  always_comb begin
    if (cmpl_wr) begin
      claim_d = '0;
      irq_d   = 1'b0;
    end else begin
      claim_d = win_valid ? win_id : '0;
      irq_d   = win_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      claim_q <= claim_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_o,
  input logic [ID_W-1:0]   claim_q,
  input logic [NSRC-1:0]   pending_q,
  input logic [NSRC-1:0]   enable_q
);

  logic cmpl;
  assign cmpl = bus_we && (bus_addr == OFS_CLAIM);

  // R3
  rsv_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q[0] && !enable_q[0]);

  // R2
  pend_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending_q & ~$past(pending_q) & ~$past(enable_q)) == '0));

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl |=> (($past(pending_q) & ~pending_q) == '0));

  // R7
  cmpl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> !irq_o);

  // R6
  line_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (claim_q != '0));

  // R6
  claim_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_q != '0) |-> ((($past(pending_q) >> claim_q) & NSRC'(1)) != '0));

endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .irq_o     (irq_o),
  .claim_q   (claim_q),
  .pending_q (pending_q),
  .enable_q  (enable_q)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        bus_we;
  logic [21:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // ---------------- behavioural reference ----------------
  int          m_prio [32];
  logic [31:0] m_en, m_pend, m_prev;
  int          m_thr, m_claim;
  bit          m_irq;
  int          nvec = 0;
  int          nbad = 0;
  string       tag = "R1";

  function automatic int model_win();
    int best = -1;
    int id = 0;
    for (int i = 1; i < 32; i++) begin
      if (m_pend[i] && m_prio[i] > m_thr && m_prio[i] > best) begin
        best = m_prio[i];
        id = i;
      end
    end
    return id;
  endfunction

  function automatic logic [31:0] model_rd(logic [21:0] a);
    if (a < 22'h80 && a[1:0] == 2'b00) return 32'(m_prio[a >> 2]);
    if (a == A_PEND)  return m_pend;
    if (a == A_EN)    return m_en;
    if (a == A_THR)   return 32'(m_thr);
    if (a == A_CLAIM) return 32'(m_claim);
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    m_en = 0; m_pend = 0; m_prev = 0; m_thr = 0; m_claim = 0; m_irq = 0;
  endtask

  task automatic model_step();
    logic [31:0] rise, clr;
    int w;
    bit cm;
    rise = src & ~m_prev & m_en;
    m_prev = src;
    w = model_win();
    cm = bus_we && bus_addr == A_CLAIM;
    clr = 0;
    if (cm && bus_wdata >= 1 && bus_wdata <= 31) clr[bus_wdata[4:0]] = 1'b1;
    m_claim = cm ? 0 : w;
    m_irq   = !cm && w != 0;
    m_pend  = ((m_pend & ~clr) | rise) & ~32'h1;
    if (bus_we) begin
      if (bus_addr < 22'h80 && bus_addr[1:0] == 2'b00 && bus_addr[6:2] != 0)
        m_prio[bus_addr[6:2]] = int'(bus_wdata[2:0]);
      if (bus_addr == A_EN)  m_en  = bus_wdata & ~32'h1;
      if (bus_addr == A_THR) m_thr = int'(bus_wdata[2:0]);
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    check(tag, bus_rdata, model_rd(bus_addr));
    check(tag, 32'(irq_o), 32'(m_irq));
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(logic [21:0] a, logic [31:0] exp, string req);
    bus_addr = a;
    tick();
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(int id);
    src[id] = 1'b1; tick();
    src[id] = 1'b0; tick();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; src = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    model_reset();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd_chk(A_PEND, 0, "R1");
    rd_chk(A_CLAIM, 0, "R1");
    rd_chk(22'h4, 0, "R1");
    rd_chk(A_THR, 0, "R1");
    check("R1", 32'(irq_o), 0);

    // R9 / R3 / R10 register behaviour
    tag = "R9";
    wr(22'h4, 32'hF);            rd_chk(22'h4, 7, "R9");
    wr(A_THR, 32'h1D);           rd_chk(A_THR, 5, "R9");
    wr(A_THR, 0);
    tag = "R3";
    wr(A_EN, 32'hFFFF_FFFF);     rd_chk(A_EN, 32'hFFFF_FFFE, "R3");
    wr(22'h0, 7);                rd_chk(22'h0, 0, "R3");
    tag = "R10";
    wr(A_EN, 0);
    wr(A_PEND, 32'hFFFF_FFFF);   rd_chk(A_PEND, 0, "R10");
    rd_chk(22'h000100, 0, "R10");
    wr(22'h4, 0);

    // R2 enable gating and level behaviour
    tag = "R2";
    wr(A_EN, 32'h2);
    pulse(2);                    rd_chk(A_PEND, 0, "R2");
    wr(22'h4, 1);
    pulse(1);                    rd_chk(A_PEND, 32'h2, "R2");
    rd_chk(A_CLAIM, 1, "R6");    check("R6", 32'(irq_o), 1);
    tag = "R7";
    wr(A_CLAIM, 1);              check("R7", 32'(irq_o), 0);
    rd_chk(A_PEND, 0, "R7");     rd_chk(A_CLAIM, 0, "R6");
    check("R6", 32'(irq_o), 0);
    tag = "R2";
    src[1] = 1'b1; tick(); tick();
    wr(A_CLAIM, 1); tick(); tick();
    rd_chk(A_PEND, 0, "R2");
    src[1] = 1'b0; tick();

    // R5 worked example: descending priorities
    tag = "R5";
    wr(22'h4, 3); wr(22'h8, 2); wr(22'hC, 1);
    wr(A_EN, 32'hE);
    pulse(1); pulse(2); pulse(3);
    rd_chk(A_PEND, 32'hE, "R5"); rd_chk(A_CLAIM, 1, "R5");
    wr(A_CLAIM, 1);
    rd_chk(A_PEND, 32'hC, "R7"); rd_chk(A_CLAIM, 2, "R5");
    wr(A_CLAIM, 2);
    rd_chk(A_PEND, 32'h8, "R7"); rd_chk(A_CLAIM, 3, "R5");
    wr(A_CLAIM, 3);
    rd_chk(A_PEND, 0, "R7");     rd_chk(A_CLAIM, 0, "R6");

    // R5 tie: lowest id wins
    wr(22'h10, 5); wr(22'h14, 5);
    wr(A_EN, 32'h3E);
    pulse(5); pulse(4);
    rd_chk(A_CLAIM, 4, "R5");
    wr(A_CLAIM, 4);
    rd_chk(A_CLAIM, 5, "R5");
    wr(A_CLAIM, 5); tick();

    // R4 threshold is strict
    tag = "R4";
    wr(A_THR, 5);
    pulse(4);
    rd_chk(A_CLAIM, 0, "R4");    check("R4", 32'(irq_o), 0);
    rd_chk(A_PEND, 32'h10, "R4");
    wr(22'h10, 6);               rd_chk(A_CLAIM, 4, "R4");
    wr(A_THR, 6);                rd_chk(A_CLAIM, 0, "R4");
    wr(A_THR, 0);                rd_chk(A_CLAIM, 4, "R4");
    wr(A_CLAIM, 4); tick();

    // R8 completion writes that must not clear
    tag = "R8";
    pulse(2);                    rd_chk(A_PEND, 32'h4, "R8");
    wr(A_CLAIM, 0);              rd_chk(A_PEND, 32'h4, "R8");
    wr(A_CLAIM, 9);              rd_chk(A_PEND, 32'h4, "R8");
    wr(A_CLAIM, 34);             rd_chk(A_PEND, 32'h4, "R8");
    rd_chk(A_CLAIM, 2, "R8");

    // R11 edge and completion of the same id on one edge
    tag = "R11";
    src[2] = 1'b1;
    wr(A_CLAIM, 2);
    src[2] = 1'b0;
    rd_chk(A_PEND, 32'h4, "R11");
    wr(A_CLAIM, 2);              rd_chk(A_PEND, 0, "R11");

    // R6 randomised traffic, compared on every clock
    tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      int k;
      src = $urandom() & $urandom();
      k = int'($urandom_range(0, 11));
      bus_we = 1'b0;
      case (k)
        0, 1: begin bus_we = 1'b1; bus_addr = 22'(4 * $urandom_range(0, 31)); bus_wdata = $urandom(); end
        2:    begin bus_we = 1'b1; bus_addr = A_EN;    bus_wdata = $urandom(); end
        3:    begin bus_we = 1'b1; bus_addr = A_THR;   bus_wdata = 32'($urandom_range(0, 7)); end
        4, 5: begin bus_we = 1'b1; bus_addr = A_CLAIM; bus_wdata = 32'($urandom_range(0, 40)); end
        6:    bus_addr = A_PEND;
        7:    bus_addr = A_EN;
        8:    bus_addr = 22'(4 * $urandom_range(0, 31));
        default: bus_addr = A_CLAIM;
      endcase
      tick();
    end
    bus_we = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule